// File: doc/BRIEF.md
# Streaming Pixel Format Unpacker

This block sits between a frame-buffer fetch engine and the colour path of a display pipeline. It accepts 32-bit memory words over a valid/ready handshake and returns one pixel per accepted output handshake. Each pixel comes out either as a palette index, for depths of 8 bits and below, or as 24-bit direct colour. A control word selects the pixel depth, the colour component order and two ordering options. A 2-bit external format-select input picks the bit layout of the 16-bit mode on builds that lack a native 565 code.

The control word and the format-select input are captured together with each accepted word. A later word can therefore use a different format while the current one is still being emitted. A combinational side output gives the number of bytes in one display line for the live depth code and a given line width in pixels. The fetch engine uses it to size its bursts.

Top module: `pix_unpack`

## Requirements
- R1: The depth code sits in control bits [3:1]. Codes 0..7 mean 1, 2, 4, 8, 16 (5551 or mux-selected), 32, 16 (565) and 12 bits per pixel. The 12-bit mode occupies a 16-bit slot, so a word holds 32, 16, 8, 4, 2, 1, 2 and 2 pixels respectively.
- R2: With control bits 9 and 10 both clear, pixel k of a word is taken from bits [k*W +: W], where W is the slot width. The least significant slot comes first.
- R3: With control bit 9 set, pixel k is taken from slot N-1-k, where N is the number of pixels per word. The whole word is read most significant slot first, whatever the value of bit 10.
- R4: With only control bit 10 set, bytes are read lowest first and the pixels inside each byte are read most significant first. For depths of 8 bits and above, bit 10 has no effect.
- R5: For depth codes 0 to 3, out_is_index is 1 and out_index holds the slot value, zero-extended. out_rgb is 0.
- R6: The direct-colour layouts hold components c0, c1 and c2 from the least significant end. 5551 uses bits [4:0], [9:5] and [14:10], and bit 15 is ignored. 565 uses [4:0], [10:5] and [15:11]. 12-bit uses [3:0], [7:4] and [11:8]. 32-bit uses [7:0], [15:8] and [23:16], and bits [31:24] are ignored. Each component is widened to 8 bits by copying its top bits into the vacated low bits.
- R7: out_rgb is {red, green, blue} with red in bits [23:16]. With control bit 8 clear, red is c0 and blue is c2. With bit 8 set, red is c2 and blue is c0.
- R8: On a build without native 565 (NATIVE565=0), depth code 4 follows fmt_mux. A value of 1 gives 5551. A value of 3 gives 565 with red taken from c2 whatever bit 8 says. Values 0 and 2 give 565 and obey bit 8. Code 6 gives 565 and obeys bit 8.
- R9: On a build with native 565 (NATIVE565=1), code 4 is always 5551 and code 6 is always 565, and fmt_mux has no effect.
- R10: line_bytes equals line_px shifted right by 3, 2 or 1 for 1, 2 and 4 bpp. It equals line_px for 8 bpp, line_px*2 for codes 4, 6 and 7, and line_px*4 for 32 bpp. It follows the live depth code in the same cycle.
- R11: in_ready is high only when no pixel of the previous word is pending. out_valid rises the cycle after a word is accepted. A pixel held while out_ready is low keeps all output values.
- R12: After reset, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 11 | Control word: depth [3:1], component swap [8], word reversal [9], in-byte reversal [10] |
| fmt_mux | input | 2 | External 16-bit layout select |
| line_px | input | PX_W | Line width in pixels |
| line_bytes | output | PX_W+2 | Bytes per line for the live depth |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Unit can take a word |
| in_word | input | WORD_W | Frame-buffer word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Consumer takes the pixel |
| out_is_index | output | 1 | Pixel is a palette index |
| out_index | output | 8 | Palette index |
| out_rgb | output | 24 | Direct colour {R,G,B} |

## Verification
A word accepted at a clock edge must show out_valid by the following falling edge. After that, each later pixel is due one edge after the previous output handshake. line_bytes is combinational and is read a short delay after its inputs change. The bench drives all inputs on falling edges and changes out_ready just after rising edges. It pushes the expected pixels into a queue when it offers a word. A monitor compares outputs only at falling edges where both valid and ready are high, and it checks that values hold across a stalled cycle. Two builds, with and without native 565, share one stimulus stream and have separate expectation queues.

// File: rtl/pix_unpack_pkg.sv
// Shared types of the pixel unpacker: colour layout, slot ordering and the
// resolved format record that is latched with every accepted word.
package pix_unpack_pkg;

    typedef enum logic [2:0] {
        COL_INDEX = 3'd0,
        COL_5551  = 3'd1,
        COL_565   = 3'd2,
        COL_444   = 3'd3,
        COL_888   = 3'd4
    } col_e;

    typedef enum logic [1:0] {
        ORD_LSB      = 2'd0,
        ORD_WORD_REV = 2'd1,
        ORD_BYTE_REV = 2'd2
    } ord_e;

    typedef struct packed {
        col_e       col;
        logic [2:0] lg_cw;   // log2 of the slot width in bits
        logic       swap;    // red taken from c2
        ord_e       ord;
    } fmt_t;

endpackage

// File: rtl/pix_fmt_decode.sv
// Resolves the control word and the external layout select into a format
// record. Assumes a 32-bit word; purely combinational.
module pix_fmt_decode
    import pix_unpack_pkg::*;
#(
    parameter bit NATIVE565 = 1'b0
) (
    input  logic [10:0] ctrl,
    input  logic [1:0]  mux_sel,
    output fmt_t        fmt
);

    logic [2:0] depth;
    logic       unused_ctrl;

    assign depth       = ctrl[3:1];
    assign unused_ctrl = ^{ctrl[0], ctrl[7:4]};

    // Map the depth code and select input onto layout, slot width and swap.
    always_comb begin
        fmt.swap = ctrl[8];
        fmt.ord  = ctrl[9]  ? ORD_WORD_REV :
                   ctrl[10] ? ORD_BYTE_REV : ORD_LSB;
        case (depth)
            3'd0, 3'd1, 3'd2, 3'd3: begin
                fmt.col   = COL_INDEX;
                fmt.lg_cw = depth;
            end
            3'd4: begin
                fmt.lg_cw = 3'd4;
                if (NATIVE565) begin
                    fmt.col = COL_5551;
                end else begin
                    fmt.col = (mux_sel == 2'd1) ? COL_5551 : COL_565;
                    if (mux_sel == 2'd3) fmt.swap = 1'b1;
                end
            end
            3'd5: begin
                fmt.col   = COL_888;
                fmt.lg_cw = 3'd5;
            end
            3'd6: begin
                fmt.col   = COL_565;
                fmt.lg_cw = 3'd4;
            end
            default: begin
                fmt.col   = COL_444;
                fmt.lg_cw = 3'd4;
            end
        endcase
    end

endmodule

// File: rtl/pix_slot_sel.sv
// Picks the slot of the current pixel out of the held word and flags the
// final pixel. Assumes lg_cw never exceeds log2(WORD_W).
module pix_slot_sel
    import pix_unpack_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0]         word,
    input  logic [2:0]                lg_cw,
    input  ord_e                      ord,
    input  logic [$clog2(WORD_W)-1:0] idx,
    output logic [WORD_W-1:0]         field,
    output logic                      last
);

    localparam int LG_WORD = $clog2(WORD_W);

    logic [LG_WORD:0]   per_word;
    logic [LG_WORD:0]   per_word_m1;
    logic [LG_WORD:0]   cw;
    logic [LG_WORD-1:0] in_byte_m;
    logic [LG_WORD-1:0] slot;
    logic [LG_WORD-1:0] shift;
    logic [WORD_W-1:0]  mask;

    // Derive slot count, slot width and the reversal mask inside a byte.
    always_comb begin
        per_word    = (LG_WORD+1)'(WORD_W >> lg_cw);
        per_word_m1 = per_word - 1'b1;
        cw          = {{LG_WORD{1'b0}}, 1'b1} << lg_cw;
        in_byte_m   = (lg_cw < 3'd3) ? LG_WORD'((8 >> lg_cw) - 1) : '0;
    end

    // Turn the pixel count into a slot number according to the ordering.
    always_comb begin
        case (ord)
            ORD_WORD_REV: slot = idx ^ per_word_m1[LG_WORD-1:0];
            ORD_BYTE_REV: slot = idx ^ in_byte_m;
            default:      slot = idx;
        endcase
        shift = LG_WORD'(slot << lg_cw);
    end

    // Extract the slot and flag the final pixel of the word.
    always_comb begin
        mask  = ~({WORD_W{1'b1}} << cw);
        field = (word >> shift) & mask;
        last  = (idx == per_word_m1[LG_WORD-1:0]);
    end

endmodule

// File: rtl/pix_color_expand.sv
// Converts a right-aligned slot into either a palette index or 8-bit-per-
// channel colour with top-bit replication. Assumes WORD_W of at least 32.
module pix_color_expand
    import pix_unpack_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] field,
    input  col_e              col,
    input  logic              swap,
    output logic              is_index,
    output logic [7:0]        index,
    output logic [23:0]       rgb
);

    logic [7:0] c0, c1, c2;
    logic       unused_hi;

    assign unused_hi = ^field[WORD_W-1:24];

    // Unpack the three components of the selected layout.
    always_comb begin
        case (col)
            COL_5551: begin
                c0 = {field[4:0],   field[4:2]};
                c1 = {field[9:5],   field[9:7]};
                c2 = {field[14:10], field[14:12]};
            end
            COL_565: begin
                c0 = {field[4:0],   field[4:2]};
                c1 = {field[10:5],  field[10:9]};
                c2 = {field[15:11], field[15:13]};
            end
            COL_444: begin
                c0 = {field[3:0],  field[3:0]};
                c1 = {field[7:4],  field[7:4]};
                c2 = {field[11:8], field[11:8]};
            end
            COL_888: begin
                c0 = field[7:0];
                c1 = field[15:8];
                c2 = field[23:16];
            end
            default: begin
                c0 = '0;
                c1 = '0;
                c2 = '0;
            end
        endcase
    end

    // Drive the index or the ordered colour triple.
    always_comb begin
        is_index = (col == COL_INDEX);
        index    = is_index ? field[7:0] : 8'd0;
        rgb      = is_index ? 24'd0 : (swap ? {c2, c1, c0} : {c0, c1, c2});
    end

endmodule

// File: rtl/pix_line_bytes.sv
// Bytes occupied by one line of line_px pixels at the given depth code.
module pix_line_bytes #(
    parameter int PX_W = 12
) (
    input  logic [2:0]      depth,
    input  logic [PX_W-1:0] px,
    output logic [PX_W+1:0] bytes
);

    logic [PX_W+1:0] ext;

    assign ext = {2'b00, px};

    // Scale the pixel count by the slot width in bytes.
    always_comb begin
        case (depth)
            3'd0:    bytes = ext >> 3;
            3'd1:    bytes = ext >> 2;
            3'd2:    bytes = ext >> 1;
            3'd3:    bytes = ext;
            3'd5:    bytes = ext << 2;
            default: bytes = ext << 1;
        endcase
    end

endmodule

// File: rtl/pix_unpack.sv
// Top of the pixel unpacker. Holds one word with its latched format and
// emits its pixels one per output handshake; a new word is taken only when
// the held one is exhausted. Assumes WORD_W = 32 for the colour layouts.
module pix_unpack
    import pix_unpack_pkg::*;
#(
    parameter int WORD_W    = 32,
    parameter int PX_W      = 12,
    parameter bit NATIVE565 = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [10:0]       cfg_ctrl,
    input  logic [1:0]        fmt_mux,
    input  logic [PX_W-1:0]   line_px,
    output logic [PX_W+1:0]   line_bytes,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_is_index,
    output logic [7:0]        out_index,
    output logic [23:0]       out_rgb
);

    localparam int LG_WORD = $clog2(WORD_W);

    fmt_t               fmt_live;
    fmt_t               fmt_q;
    logic [2:0]         depth_q;
    logic               full_q;
    logic [WORD_W-1:0]  word_q;
    logic [LG_WORD-1:0] idx_q;
    logic [WORD_W-1:0]  field;
    logic               last_px;

    pix_fmt_decode #(.NATIVE565(NATIVE565)) u_dec (
        .ctrl    (cfg_ctrl),
        .mux_sel (fmt_mux),
        .fmt     (fmt_live)
    );

    pix_slot_sel #(.WORD_W(WORD_W)) u_sel (
        .word  (word_q),
        .lg_cw (fmt_q.lg_cw),
        .ord   (fmt_q.ord),
        .idx   (idx_q),
        .field (field),
        .last  (last_px)
    );

    pix_color_expand #(.WORD_W(WORD_W)) u_col (
        .field    (field),
        .col      (fmt_q.col),
        .swap     (fmt_q.swap),
        .is_index (out_is_index),
        .index    (out_index),
        .rgb      (out_rgb)
    );

    pix_line_bytes #(.PX_W(PX_W)) u_lb (
        .depth (cfg_ctrl[3:1]),
        .px    (line_px),
        .bytes (line_bytes)
    );

    assign in_ready  = !full_q;
    assign out_valid = full_q;

    // Capture a word with its format, then step through its pixels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            word_q  <= '0;
            idx_q   <= '0;
            depth_q <= '0;
            fmt_q   <= '{col: COL_INDEX, lg_cw: 3'd0, swap: 1'b0, ord: ORD_LSB};
        end else if (in_valid && in_ready) begin
            full_q  <= 1'b1;
            word_q  <= in_word;
            idx_q   <= '0;
            depth_q <= cfg_ctrl[3:1];
            fmt_q   <= fmt_live;
        end else if (full_q && out_ready) begin
            if (last_px) full_q <= 1'b0;
            else         idx_q  <= idx_q + 1'b1;
        end
    end

    assert_accept_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_index)
                                   && $stable(out_rgb) && $stable(out_is_index));

    assert_index_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_is_index == (depth_q < 3'd4));

    assert_index_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_is_index |->
            out_rgb == 24'd0 && {1'b0, out_index} < (9'd1 << (4'd1 << depth_q)));

    assert_eight_bpp_bytes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_ctrl[3:1] == 3'd3 |-> line_bytes == {2'b00, line_px});

endmodule

// File: tb/pix_unpack_tb.sv
// Scoreboard bench: the driver queues expected pixels for both builds,
// the monitor pops and compares them at each output handshake.
module pix_unpack_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PX_W       = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [10:0] cfg_ctrl;
    logic [1:0]  fmt_mux;
    logic [PX_W-1:0] line_px;
    logic [PX_W+1:0] line_bytes, line_bytes_n;
    logic        in_valid;
    logic        in_ready, in_ready_n;
    logic [31:0] in_word;
    logic        out_valid, out_valid_n;
    logic        out_ready;
    logic        out_is_index, out_is_index_n;
    logic [7:0]  out_index, out_index_n;
    logic [23:0] out_rgb, out_rgb_n;

    int checks = 0;
    int errors = 0;
    logic [32:0] q_i[$];
    logic [32:0] q_n[$];
    string       t_i[$];
    string       t_n[$];
    bit          stall_mode = 1'b0;
    int          cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_unpack #(.WORD_W(32), .PX_W(PX_W), .NATIVE565(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .fmt_mux(fmt_mux),
        .line_px(line_px), .line_bytes(line_bytes), .in_valid(in_valid),
        .in_ready(in_ready), .in_word(in_word), .out_valid(out_valid),
        .out_ready(out_ready), .out_is_index(out_is_index),
        .out_index(out_index), .out_rgb(out_rgb));

    pix_unpack #(.WORD_W(32), .PX_W(PX_W), .NATIVE565(1'b1)) dut_n (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .fmt_mux(fmt_mux),
        .line_px(line_px), .line_bytes(line_bytes_n), .in_valid(in_valid),
        .in_ready(in_ready_n), .in_word(in_word), .out_valid(out_valid_n),
        .out_ready(out_ready), .out_is_index(out_is_index_n),
        .out_index(out_index_n), .out_rgb(out_rgb_n));

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int slot_w(input int d);
        case (d)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            5: return 32;
            default: return 16;
        endcase
    endfunction

    function automatic int widen(input int x, input int n);
        if (n == 8) return x;
        return ((x << (8 - n)) | (x >> (2 * n - 8))) & 255;
    endfunction

    // Expected {is_index, index, rgb} of pixel k, written from the requirements.
    function automatic logic [32:0] model(input logic [31:0] w, input int k,
                                          input logic [10:0] ctrl,
                                          input logic [1:0] mux, input bit native);
        int d, cw, n, pos, ppb, f, kind, c0, c1, c2;
        bit bgr;
        d  = int'(ctrl[3:1]);
        cw = slot_w(d);
        n  = 32 / cw;
        if (ctrl[9]) pos = (n - 1 - k) * cw;
        else if (ctrl[10] && cw < 8) begin
            ppb = 8 / cw;
            pos = (k / ppb) * 8 + (ppb - 1 - (k % ppb)) * cw;
        end else pos = k * cw;
        f = int'((64'(w) >> pos) & ((64'd1 << cw) - 1));
        if (d < 4) return {1'b1, 8'(f), 24'd0};
        bgr = ctrl[8];
        // kind: 0=5551 1=565 2=444 3=888
        case (d)
            5: kind = 3;
            7: kind = 2;
            6: kind = 1;
            default: begin
                if (native) kind = 0;
                else begin
                    kind = (mux == 2'd1) ? 0 : 1;
                    if (mux == 2'd3) bgr = 1'b1;
                end
            end
        endcase
        case (kind)
            0: begin c0 = widen(f & 31, 5); c1 = widen((f >> 5) & 31, 5); c2 = widen((f >> 10) & 31, 5); end
            1: begin c0 = widen(f & 31, 5); c1 = widen((f >> 5) & 63, 6); c2 = widen((f >> 11) & 31, 5); end
            2: begin c0 = widen(f & 15, 4); c1 = widen((f >> 4) & 15, 4); c2 = widen((f >> 8) & 15, 4); end
            default: begin c0 = f & 255; c1 = (f >> 8) & 255; c2 = (f >> 16) & 255; end
        endcase
        if (bgr) return {1'b0, 8'd0, 8'(c2), 8'(c1), 8'(c0)};
        return {1'b0, 8'd0, 8'(c0), 8'(c1), 8'(c2)};
    endfunction

    function automatic logic [10:0] mk(input int d, input bit bgr,
                                       input bit wrev, input bit brev);
        return {brev, wrev, bgr, 4'b0, 3'(d), 1'b0};
    endfunction

    // Offer one word; queue the expected pixels of both builds.
    task automatic send_word(input logic [10:0] ctrl, input logic [1:0] mux,
                             input logic [31:0] w, input string tag);
        int n, d;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        cfg_ctrl = ctrl;
        fmt_mux  = mux;
        in_word  = w;
        in_valid = 1'b1;
        d = int'(ctrl[3:1]);
        n = 32 / slot_w(d);
        for (int k = 0; k < n; k++) begin
            q_i.push_back(model(w, k, ctrl, mux, 1'b0));
            t_i.push_back(tag);
            q_n.push_back(model(w, k, ctrl, mux, 1'b1));
            t_n.push_back((d == 4 || d == 6) ? "R9" : tag);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && !in_ready, "R11", "valid after accept",
              {out_valid, in_ready}, 2'b10);
    endtask

    // Consumer readiness changes just after rising edges.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        out_ready <= stall_mode ? ((cyc % 3) != 1) : 1'b1;
    end

    // Monitor: compare at handshakes, check hold across stalls.
    logic        stall_prev = 1'b0;
    logic [32:0] held_i;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stall_prev)
                check(out_valid && {out_is_index, out_index, out_rgb} == held_i,
                      "R11", "held pixel", {out_is_index, out_index, out_rgb}, held_i);
            stall_prev = out_valid && !out_ready;
            held_i     = {out_is_index, out_index, out_rgb};
            if (out_valid && out_ready) begin
                if (q_i.size() == 0) begin
                    check(1'b0, "R11", "unexpected pixel", 1, 0);
                end else begin
                    logic [32:0] e;
                    string tg;
                    e  = q_i.pop_front();
                    tg = t_i.pop_front();
                    check({out_is_index, out_index, out_rgb} == e, tg, "pixel",
                          {out_is_index, out_index, out_rgb}, e);
                    e  = q_n.pop_front();
                    tg = t_n.pop_front();
                    check(out_valid_n && {out_is_index_n, out_index_n, out_rgb_n} == e,
                          tg, "pixel native", {out_is_index_n, out_index_n, out_rgb_n}, e);
                end
            end
        end
    end

    task automatic finish_run;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R11", "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int exp_lb[8];
        rst_n = 1'b0; in_valid = 1'b0; cfg_ctrl = '0; fmt_mux = '0;
        in_word = '0; line_px = '0; out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid && in_ready, "R12", "reset state", {out_valid, in_ready}, 2'b01);

        // R10: bytes per line for every depth code at 640 pixels.
        exp_lb = '{80, 160, 320, 640, 1280, 2560, 1280, 1280};
        for (int d = 0; d < 8; d++) begin
            cfg_ctrl = mk(d, 0, 0, 0);
            line_px  = 12'd640;
            #1;
            check(int'(line_bytes) == exp_lb[d], "R10", "line bytes", line_bytes, exp_lb[d]);
        end
        cfg_ctrl = mk(0, 0, 0, 0); line_px = 12'd100; #1;
        check(int'(line_bytes) == 12, "R10", "line bytes truncated", line_bytes, 12);

        send_word(mk(3, 0, 0, 0), 2'd0, 32'h4433_2211, "R5");
        send_word(mk(0, 0, 0, 0), 2'd0, 32'h8000_0001, "R1");
        send_word(mk(1, 0, 0, 0), 2'd0, 32'h1B1B_E4E4, "R2");
        send_word(mk(2, 0, 0, 1), 2'd0, 32'h8765_4321, "R4");
        send_word(mk(3, 0, 0, 1), 2'd0, 32'hA1B2_C3D4, "R4");
        send_word(mk(1, 0, 1, 1), 2'd0, 32'h0123_4567, "R3");
        send_word(mk(3, 0, 1, 0), 2'd0, 32'h4433_2211, "R3");
        send_word(mk(4, 0, 1, 0), 2'd1, 32'hFFFF_7C1F, "R3");
        send_word(mk(4, 0, 0, 0), 2'd1, 32'h8000_7FFF, "R6");
        send_word(mk(4, 0, 0, 0), 2'd1, 32'h03E0_801F, "R8");
        send_word(mk(4, 0, 0, 0), 2'd3, 32'hF800_001F, "R8");
        send_word(mk(4, 1, 0, 0), 2'd0, 32'h07E0_F81F, "R8");
        send_word(mk(4, 0, 0, 0), 2'd2, 32'h1234_ABCD, "R8");
        send_word(mk(6, 0, 0, 0), 2'd1, 32'hF800_07E0, "R6");
        send_word(mk(6, 1, 0, 0), 2'd3, 32'h0010_F800, "R7");
        send_word(mk(7, 0, 0, 0), 2'd0, 32'h0F00_0ABC, "R6");
        send_word(mk(5, 0, 0, 0), 2'd0, 32'hFF12_3456, "R6");
        send_word(mk(5, 1, 0, 0), 2'd0, 32'h0012_3456, "R7");
        send_word(mk(5, 0, 1, 1), 2'd0, 32'h00AA_BBCC, "R3");

        stall_mode = 1'b1;
        send_word(mk(0, 0, 0, 1), 2'd0, 32'hDEAD_BEEF, "R11");
        send_word(mk(3, 1, 1, 0), 2'd0, 32'hCAFE_F00D, "R11");
        send_word(mk(4, 1, 0, 0), 2'd2, 32'h5A5A_A5A5, "R11");
        send_word(mk(2, 0, 0, 0), 2'd0, 32'hFEDC_BA98, "R11");

        for (int i = 0; i < 2000 && (q_i.size() != 0 || out_valid); i++) @(negedge clk);
        check(q_i.size() == 0 && !out_valid, "R11", "all pixels drained",
              q_i.size(), 0);
        finish_run();
    end

endmodule